// File: doc/BRIEF.md
# Hybrid Vedic Array Multiplier

This block multiplies two unsigned operands of equal width and returns the full double-width product. The array is built in the vertical-and-crosswise style. A 2x2 cell is the leaf. Each larger multiplier is made from four half-width multipliers: low-by-low, low-by-high, high-by-low and high-by-high. Their partial products are summed by carry-select adders.

Each adder works in two halves. A Han-Carlson parallel-prefix network adds the lower half and also forms the upper-half sum for a carry-in of zero. An excess-one converter (an incrementer) forms the carry-in-of-one alternative from that sum. A multiplexer driven by the lower half's carry picks between the two.

The operand width is a power of two of at least 4; the tested builds are 4x4 and 8x8. An optional output register turns the block into a one-cycle-latency stage. Without it, the block is purely combinational.

Top module: `vedic_mult_top`

## Requirements
- R1: For every pair of unsigned operands, the product output equals the exact unsigned product of the operands, 2*WIDTH bits wide.
- R2: Product bit 0 equals a[0]&b[0], and product bit 1 equals (a[1]&b[0]) xor (a[0]&b[1]). These bits come straight from the low-by-low 2x2 cell, with no addition.
- R3: When either operand is zero, the product is zero.
- R4: When either operand is one, the product equals the other operand, zero-extended.
- R5: All-ones times all-ones gives 2^(2*WIDTH) - 2^(WIDTH+1) + 1, with no bit lost at the top of the product.
- R6: With OUT_REG=1, the product of the operands present at a rising clock edge appears after that edge and holds until the next edge. With OUT_REG=0, the product follows the operands in the same cycle.
- R7: With OUT_REG=1, a low rst_n sampled at a rising edge clears the product to zero. With OUT_REG=0, rst_n has no effect on the product.
- R8: A WIDTH=8 build multiplies correctly, including the corner operands 0, 1, 128 and 255.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Synchronous active-low reset of the output register |
| a | input | WIDTH | Multiplicand, unsigned |
| b | input | WIDTH | Multiplier, unsigned |
| prod | output | 2*WIDTH | Unsigned product |

## Verification
The hardest case to reach from the ports is the one where the lower section's carry selects the excess-one result in every adder at once, while the high cross terms also overflow into the top carry. This happens only for operand pairs near all-ones, and for particular mixes of high and low halves.

For the 4x4 build, the bench walks all 256 operand pairs, so every carry-select path is taken at least once. For the 8x8 build, it crosses a set of corner values (0, 1, 2, 127, 128, 254, 255) with each other, then adds random pairs. A behavioural reference with a queue models the one-cycle latency of the registered build.

// File: rtl/vm_pkg.sv
// Package: shared helpers for the hybrid Vedic multiplier.
// Assumes: widths are passed as positive integers.
package vm_pkg;

    // Purpose: tell whether an operand width can be tiled down to 2x2 cells.
    function automatic bit width_ok(input int w);
        return (w >= 4) && ((w & (w - 1)) == 0);
    endfunction

    // Purpose: split point of a carry-select adder (size of the lower section).
    function automatic int low_part(input int w);
        return w / 2;
    endfunction

endpackage

// File: rtl/vm_hc_add.sv
// Module: Han-Carlson parallel-prefix adder with carry-in zero.
// What: sum = x + y with carry out. Odd bit positions get a full prefix tree of
//       log2(W) levels; even positions are completed by one final level.
// Assumes: W >= 2.
module vm_hc_add #(
    parameter int W = 4
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    output logic [W-1:0] s,
    output logic         co
);
    localparam int LVLS = $clog2(W);

    logic [W-1:0] gen0;
    logic [W-1:0] prp0;
    logic [W-1:0] gpre;

    // Purpose: bitwise generate and propagate terms.
    always_comb begin
        gen0 = x & y;
        prp0 = x ^ y;
    end

    // Purpose: prefix tree over odd positions, then the even fix-up level.
    always_comb begin
        logic [W-1:0] gcur, pcur, gnxt, pnxt;
        gcur = gen0;
        pcur = prp0;
        for (int lv = 0; lv < LVLS; lv++) begin
            gnxt = gcur;
            pnxt = pcur;
            for (int i = 1; i < W; i += 2) begin
                if (i >= (1 << lv)) begin
                    gnxt[i] = gcur[i] | (pcur[i] & gcur[i - (1 << lv)]);
                    pnxt[i] = pcur[i] & pcur[i - (1 << lv)];
                end
            end
            gcur = gnxt;
            pcur = pnxt;
        end
        for (int i = 2; i < W; i += 2) begin
            gcur[i] = gcur[i] | (pcur[i] & gcur[i - 1]);
        end
        gpre = gcur;
    end

    // Purpose: final sum bits from propagate and incoming prefix carries.
    always_comb begin
        s[0] = prp0[0];
        for (int i = 1; i < W; i++) begin
            s[i] = prp0[i] ^ gpre[i - 1];
        end
        co = gpre[W-1];
    end
endmodule

// File: rtl/vm_bec.sv
// Module: excess-one converter.
// What: y = x + 1 modulo 2^W; co is set when every input bit is one.
// Assumes: W >= 1.
module vm_bec #(
    parameter int W = 4
) (
    input  logic [W-1:0] x,
    output logic [W-1:0] y,
    output logic         co
);
    // Purpose: toggle each bit while all lower bits are one.
    always_comb begin
        logic run;
        run = 1'b1;
        for (int i = 0; i < W; i++) begin
            y[i] = x[i] ^ run;
            run  = run & x[i];
        end
        co = run;
    end
endmodule

// File: rtl/vm_hcsa.sv
// Module: hybrid carry-select adder.
// What: the lower section is a prefix adder. The upper section's carry-in-zero
//       sum comes from a prefix adder, and its carry-in-one sum from an excess-one
//       converter on that result. The lower carry picks between the two.
// Assumes: W >= 3, no carry in.
module vm_hcsa #(
    parameter int W = 6
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] s,
    output logic         co
);
    import vm_pkg::*;
    localparam int LO = low_part(W);
    localparam int HI = W - LO;

    logic [LO-1:0] s_lo;
    logic          c_lo;
    logic [HI-1:0] s_h0;
    logic          c_h0;
    logic [HI:0]   s_h1;
    logic          bec_unused_co;

    vm_hc_add #(.W(LO)) u_lo (.x(a[LO-1:0]), .y(b[LO-1:0]), .s(s_lo), .co(c_lo));
    vm_hc_add #(.W(HI)) u_hi (.x(a[W-1:LO]), .y(b[W-1:LO]), .s(s_h0), .co(c_h0));
    vm_bec    #(.W(HI + 1)) u_inc (.x({c_h0, s_h0}), .y(s_h1), .co(bec_unused_co));

    // Purpose: select the upper result with the lower section's carry.
    always_comb begin
        s[LO-1:0] = s_lo;
        if (c_lo) begin
            {co, s[W-1:LO]} = s_h1;
        end else begin
            {co, s[W-1:LO]} = {c_h0, s_h0};
        end
    end
endmodule

// File: rtl/vm_mul2.sv
// Module: 2x2 vertical-and-crosswise cell.
// What: p = a * b for 2-bit operands, using half adders on the cross terms.
// Assumes: unsigned operands.
module vm_mul2 (
    input  logic [1:0] a,
    input  logic [1:0] b,
    output logic [3:0] p
);
    // Purpose: vertical term, crosswise pair, then the high vertical with its carry.
    always_comb begin
        logic cross_c;
        logic top;
        p[0]    = a[0] & b[0];
        p[1]    = (a[1] & b[0]) ^ (a[0] & b[1]);
        cross_c = (a[1] & b[0]) & (a[0] & b[1]);
        top     = a[1] & b[1];
        p[2]    = top ^ cross_c;
        p[3]    = top & cross_c;
    end
endmodule

// File: rtl/vm_tile.sv
// Module: N x N multiplier tile, built by recursion down to 2x2 cells.
// What: p = LL + (LH + HL) << N/2 + HH << N. The bottom N/2 bits of LL go
//       straight to the output; everything else goes through hybrid adders.
// Assumes: N is a power of two, N >= 2.
module vm_tile #(
    parameter int N = 4
) (
    input  logic [N-1:0]   a,
    input  logic [N-1:0]   b,
    output logic [2*N-1:0] p
);
    localparam int H = N / 2;

    generate
        if (N == 2) begin : g_leaf
            vm_mul2 u_cell (.a(a), .b(b), .p(p));
        end else begin : g_split
            logic [N-1:0]   pp_ll, pp_lh, pp_hl, pp_hh;
            logic [N-1:0]   mid_s;
            logic           mid_c;
            logic [N+H-1:0] up_a, up_b, up_s;
            logic           up_unused_co;

            vm_tile #(.N(H)) u_ll (.a(a[H-1:0]), .b(b[H-1:0]), .p(pp_ll));
            vm_tile #(.N(H)) u_lh (.a(a[H-1:0]), .b(b[N-1:H]), .p(pp_lh));
            vm_tile #(.N(H)) u_hl (.a(a[N-1:H]), .b(b[H-1:0]), .p(pp_hl));
            vm_tile #(.N(H)) u_hh (.a(a[N-1:H]), .b(b[N-1:H]), .p(pp_hh));

            vm_hcsa #(.W(N)) u_mid (.a(pp_lh), .b(pp_hl), .s(mid_s), .co(mid_c));

            // Purpose: line up the high and low partial products against the cross sum.
            always_comb begin
                up_a = {pp_hh, pp_ll[N-1:H]};
                up_b = {{(H-1){1'b0}}, mid_c, mid_s};
            end

            vm_hcsa #(.W(N + H)) u_up (.a(up_a), .b(up_b), .s(up_s), .co(up_unused_co));

            // Purpose: assemble the product from the pass-through bits and the upper sum.
            always_comb begin
                p = {up_s, pp_ll[H-1:0]};
            end
        end
    endgenerate
endmodule

// File: rtl/vedic_mult_top.sv
// Module: top of the hybrid Vedic multiplier.
// What: unsigned WIDTH x WIDTH multiply with an optional output register.
//       The register has a synchronous active-low reset.
// Assumes: WIDTH is a power of two >= 4; OUT_REG is 0 or 1.
module vedic_mult_top #(
    parameter int WIDTH   = 4,
    parameter bit OUT_REG = 1'b1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [WIDTH-1:0]     a,
    input  logic [WIDTH-1:0]     b,
    output logic [2*WIDTH-1:0]   prod
);
    import vm_pkg::*;
    localparam int PW = 2 * WIDTH;

    logic [PW-1:0]    prod_c;
    logic [WIDTH-1:0] seen_a, seen_b;
    logic             seen_vld;

    generate
        if (!width_ok(WIDTH)) begin : g_bad_width
            $error("vedic_mult_top: WIDTH must be a power of two of at least 4");
        end
    endgenerate

    vm_tile #(.N(WIDTH)) u_arr (.a(a), .b(b), .p(prod_c));

    generate
        if (OUT_REG) begin : g_reg
            logic [PW-1:0] prod_q;
            // Purpose: capture the product; the reset clears it.
            always_ff @(posedge clk) begin
                if (!rst_n) prod_q <= '0;
                else        prod_q <= prod_c;
            end
            // Purpose: operand copies aligned with prod, used only by the checks below.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    seen_a   <= '0;
                    seen_b   <= '0;
                    seen_vld <= 1'b0;
                end else begin
                    seen_a   <= a;
                    seen_b   <= b;
                    seen_vld <= 1'b1;
                end
            end
            assign prod = prod_q;
        end else begin : g_comb
            assign prod     = prod_c;
            assign seen_a   = a;
            assign seen_b   = b;
            assign seen_vld = 1'b1;
        end
    endgenerate

    // R1 / R6: output equals the exact product of the operands it belongs to
    p_exact_r1: assert property (@(posedge clk) disable iff (!rst_n)
        seen_vld |-> (prod == ({{WIDTH{1'b0}}, seen_a} * {{WIDTH{1'b0}}, seen_b})));

    // R2: the two low product bits come from the low-by-low cell
    p_lowbits_r2: assert property (@(posedge clk) disable iff (!rst_n)
        seen_vld |-> (prod[1:0] == {(seen_a[1] & seen_b[0]) ^ (seen_a[0] & seen_b[1]),
                                    seen_a[0] & seen_b[0]}));

    // R3: a zero operand gives a zero product
    p_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_vld && (seen_a == '0 || seen_b == '0)) |-> (prod == '0));

    // R4: a unit operand passes the other one through
    p_ident_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_vld && seen_b == WIDTH'(1)) |-> (prod == PW'(seen_a)));

    // R5: all-ones squared keeps its top bit set and bit 0 set
    p_max_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_vld && (&seen_a) && (&seen_b)) |-> (prod[PW-1] && prod[0] && !prod[1]));
endmodule

// File: tb/sim_vedic_mult_top.sv
module sim_vedic_mult_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [3:0]  a4, b4;
    logic [7:0]  p4;
    logic [7:0]  a8, b8;
    logic [15:0] p8;

    int          checks = 0;
    int          errors = 0;
    longint      exp_q[$];
    string       tag_q[$];

    always #5 clk = ~clk;

    vedic_mult_top #(.WIDTH(4), .OUT_REG(1'b1)) u0 (
        .clk(clk), .rst_n(rst_n), .a(a4), .b(b4), .prod(p4));
    vedic_mult_top #(.WIDTH(8), .OUT_REG(1'b0)) u1 (
        .clk(clk), .rst_n(rst_n), .a(a8), .b(b8), .prod(p8));

    task automatic chk(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic string tagf(input longint x, input longint y, input longint mx,
                                   input string dflt);
        if (x == mx && y == mx) return "R5";
        if (x == 0 || y == 0)   return "R3";
        if (x == 1 || y == 1)   return "R4";
        return dflt;
    endfunction

    // One clock step: check current outputs, then apply new operands.
    task automatic step(input logic [3:0] na4, input logic [3:0] nb4,
                        input logic [7:0] na8, input logic [7:0] nb8);
        longint prev;
        bit     have;
        have = 1'b0;
        prev = 0;
        @(negedge clk);
        if (exp_q.size() > 0) begin
            prev = exp_q.pop_front();
            have = 1'b1;
            chk(tag_q.pop_front(), longint'(p4), prev);
        end
        chk(tagf(a8, b8, 255, "R8"), longint'(p8), longint'(a8) * longint'(b8));
        chk("R2", longint'(p8[1:0]),
            longint'({(a8[1] & b8[0]) ^ (a8[0] & b8[1]), a8[0] & b8[0]}));
        a4 = na4; b4 = nb4; a8 = na8; b8 = nb8;
        exp_q.push_back(longint'(na4) * longint'(nb4));
        tag_q.push_back(tagf(na4, nb4, 15, "R1"));
        #1;
        if (have) chk("R6", longint'(p4), prev);  // registered output must not follow new inputs
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        a4 = 4'd5; b4 = 4'd7; a8 = 8'd200; b8 = 8'd3;
        exp_q.delete();
        tag_q.delete();
        repeat (2) @(negedge clk);
        chk("R7", longint'(p4), 0);
        chk("R7", longint'(p8), 600);
        rst_n = 1'b1;
        exp_q.push_back(35);  // captured at the first edge after release
        tag_q.push_back("R6");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int corner[7] = '{0, 1, 2, 127, 128, 254, 255};
        rst_n = 1'b0;
        a4 = '0; b4 = '0; a8 = '0; b8 = '0;
        do_reset();
        // R1 exhaustive 4x4, with random 8x8 alongside
        for (int i = 0; i < 256; i++) begin
            step(4'(i >> 4), 4'(i), 8'($urandom), 8'($urandom));
        end
        // R8 corner crosses for 8x8
        for (int i = 0; i < 7; i++) begin
            for (int j = 0; j < 7; j++) begin
                step(4'(i * 2 + 1), 4'(j + 9), 8'(corner[i]), 8'(corner[j]));
            end
        end
        // mid-run reset, R7
        do_reset();
        for (int k = 0; k < 1500; k++) begin
            step(4'($urandom), 4'($urandom), 8'($urandom), 8'($urandom));
        end
        step(4'hF, 4'hF, 8'hFF, 8'hFF);
        step(4'd0, 4'd0, 8'd0, 8'd0);
        @(negedge clk);
        if (exp_q.size() > 0) chk(tag_q.pop_front(), longint'(p4), exp_q.pop_front());
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule